// File: doc/BRIEF.md
# Serial Memory Page Write Controller

This block is the write side of a two-wire serial memory target. It sits above the bit-level layer and takes already decoded bus events: start, stop, a received byte, and a flag that says a byte is only partly shifted in. A write transaction has a fixed order. A device-select byte comes first, then the high and low bytes of a 16-bit word address, then one or more data bytes. The target acknowledges each of them. Data bytes are collected in a page buffer, and the write pointer wraps inside the current page. The stop condition decides whether an internal nonvolatile write cycle starts. That cycle is modelled by a busy counter. When the counter runs out, only the buffer columns that were loaded are copied into the storage model.

The address space has three regions. The first is a main array with large pages. The second is a small control-register page. The third is a one-byte status register. The control page stays locked until two earlier, separate status writes have committed 02h and then 06h. Two bits of control byte 0 select a write-protected part of the main array. Writes that are dropped, either because the target is protected or because the control page is locked, are still acknowledged, but they start no cycle. A storage peek port lets the surrounding logic and the bench see the committed contents.

Top module: `pgwr_ctrl`

## Requirements
- R1: A device-select byte is acknowledged only when bits [7:1] equal DEV_ID and bit 0 is 0. After a mismatch, no byte is acknowledged until the next start. After a match, the next two bytes set the word address (high byte first) and are acknowledged.
- R2: Each accepted byte raises `ack` for exactly one cycle, in the cycle after the byte event. Each data byte then moves `wptr` on by one inside its page.
- R3: In the main array (addresses below ARR_BYTES, pages of ARR_PAGE bytes), the pointer wraps from the last column of a page to column 0 of the same page. Example: 24 bytes written from 0x0030 fill 0x30..0x3F and then 0x00..0x07, and leave `wptr` at 0x0008.
- R4: A byte loaded beyond the page size overwrites the byte loaded earlier in the same column. Only the last value in each column is committed.
- R5: The control page (CTL_BASE .. CTL_BASE+CTL_PAGE-1) wraps with a page of CTL_PAGE bytes.
- R6: A stop, with `mid_byte` low, that follows at least one complete data byte of an accepted write holds `busy` high for exactly BUSY_CYC cycles, starting in the cycle after the stop. Loaded columns are committed as `busy` falls. Columns that were not loaded keep their old contents.
- R7: A stop with `mid_byte` high, or a stop before any complete data byte, starts no busy cycle and leaves storage unchanged.
- R8: While `busy` is high, every input event is ignored and `ack` stays low. After `busy` falls, a byte with no preceding start is not acknowledged.
- R9: Bits [1:0] of control byte 0 protect the main array: 0 protects nothing, 1 the top quarter, 2 the top half, 3 all of it. A write into a protected address is acknowledged at every byte, starts no cycle and changes nothing. Later transactions are still acknowledged.
- R10: The status register at STAT_ADDR arms the control page when 02h is committed. A later, separate commit of 06h while the page is armed or open opens it. Any other committed value locks it. Writes to the control page while it is not open are acknowledged and dropped, with no busy cycle.
- R11: After reset, `ack` and `busy` are low, `wptr` is 0, all storage reads 0 and the control page is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| ev_byte | input | 1 | A full byte was received (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| mid_byte | input | 1 | Some bits of a byte received but not all, sampled with `ev_stop` |
| ack | output | 1 | Acknowledge for the byte taken in the previous cycle |
| busy | output | 1 | Internal write cycle in progress |
| wptr | output | 16 | Current word address pointer |
| peek_addr | input | 16 | Storage observation address |
| peek_data | output | 8 | Committed storage byte at `peek_addr` (0 outside every region) |

## Verification
The bench builds the block with BUSY_CYC = 12 and keeps the default 256-byte main array with 64-byte pages. The short busy window lets the exact busy length be counted and makes it cheap to send events inside the window. The 256-byte array gives four pages, so each protection quarter is exactly one page. Wrap at the page end, overwrite after more than 64 bytes, and protection of the top quarter versus the top half can then all be reached with only a few transactions. A behavioural model runs in parallel and is compared on `ack`, `busy` and `wptr` every cycle. Directed peeks check the committed bytes.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {RG_NONE, RG_ARR, RG_CTL, RG_STAT} region_e;
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA} st_e;
  typedef enum logic [1:0] {LK_SHUT, LK_ARMED, LK_OPEN} lock_e;

  // Which region a word address falls in
  function automatic region_e region_of(input logic [15:0] a, input int arr_bytes,
                                        input logic [15:0] ctl_base, input int ctl_page,
                                        input logic [15:0] stat_addr);
    if (int'(a) < arr_bytes)
      return RG_ARR;
    else if (int'(a) >= int'(ctl_base) && int'(a) < int'(ctl_base) + ctl_page)
      return RG_CTL;
    else if (a == stat_addr)
      return RG_STAT;
    return RG_NONE;
  endfunction

  // Column mask of the page that belongs to a region
  function automatic logic [15:0] page_mask(input region_e r, input int arr_page,
                                            input int ctl_page);
    case (r)
      RG_ARR:  return 16'(arr_page - 1);
      RG_CTL:  return 16'(ctl_page - 1);
      default: return 16'd0;
    endcase
  endfunction

  // Next pointer value: column + 1 modulo page, page bits kept
  function automatic logic [15:0] step_addr(input logic [15:0] a, input logic [15:0] m);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // Main-array protection selected by a two-bit field
  function automatic logic guarded(input logic [15:0] a, input logic [1:0] bp,
                                   input int arr_bytes);
    case (bp)
      2'd0:    return 1'b0;
      2'd1:    return int'(a) >= (arr_bytes / 4) * 3;
      2'd2:    return int'(a) >= arr_bytes / 2;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
  parameter int PAGE = 64,
  localparam int CW = $clog2(PAGE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  ld_en,
  input  logic [CW-1:0]         ld_col,
  input  logic [7:0]            ld_data,
  output logic [PAGE-1:0][7:0]  pb_data,
  output logic [PAGE-1:0]       pb_vld
);

  for (genvar c = 0; c < PAGE; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pb_data[c] <= '0;
        pb_vld[c]  <= 1'b0;
      end else if (clr) begin
        pb_vld[c]  <= 1'b0;
      end else if (ld_en && ld_col == CW'(c)) begin
        pb_data[c] <= ld_data;
        pb_vld[c]  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter logic [6:0]  DEV_ID    = 7'h6F,
  parameter int          BUSY_CYC  = 40,
  parameter int          ARR_BYTES = 256,
  parameter int          ARR_PAGE  = 64,
  parameter int          CTL_PAGE  = 8,
  parameter logic [15:0] CTL_BASE  = 16'h4000,
  parameter logic [15:0] STAT_ADDR = 16'h400F,
  localparam int CW = $clog2(ARR_PAGE),
  localparam int NW = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_byte,
  input  logic [7:0]    rx_byte,
  input  logic          mid_byte,
  input  logic [1:0]    prot_bits,
  input  logic          ctl_open,
  output logic          ack,
  output logic          busy,
  output logic [15:0]   wptr,
  output logic          ld_en,
  output logic [CW-1:0] ld_col,
  output logic          clr,
  output logic          commit,
  output logic          stop_commit,
  output region_e       cm_region,
  output logic [15:0]   cm_base
);

  st_e           st_q;
  logic [NW-1:0] cnt_q;
  region_e       rg_q;
  logic          drop_q, got_q, ack_q;
  logic [15:0]   wptr_q, msk, nxt_addr;
  region_e       nxt_rg;
  logic          nxt_drop, live;

  assign busy   = cnt_q != '0;
  assign commit = cnt_q == NW'(1);
  assign live   = !busy;
  assign clr    = live && ev_start;
  assign stop_commit = live && !ev_start && ev_stop && st_q == S_DATA &&
                       got_q && !mid_byte && !drop_q;
  assign ld_en  = live && !ev_start && !ev_stop && ev_byte && st_q == S_DATA;
  assign msk    = page_mask(rg_q, ARR_PAGE, CTL_PAGE);
  assign ld_col = wptr_q[CW-1:0] & msk[CW-1:0];

  always_comb begin
    nxt_addr = {wptr_q[15:8], rx_byte};
    nxt_rg   = region_of(nxt_addr, ARR_BYTES, CTL_BASE, CTL_PAGE, STAT_ADDR);
    nxt_drop = (nxt_rg == RG_NONE) ||
               (nxt_rg == RG_ARR && guarded(nxt_addr, prot_bits, ARR_BYTES)) ||
               (nxt_rg == RG_CTL && !ctl_open);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      rg_q   <= RG_NONE;
      drop_q <= 1'b1;
      got_q  <= 1'b0;
      ack_q  <= 1'b0;
      wptr_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (busy) begin
        cnt_q <= cnt_q - NW'(1);
      end else if (ev_start) begin
        st_q  <= S_DEV;
        got_q <= 1'b0;
      end else if (ev_stop) begin
        if (stop_commit) cnt_q <= NW'(BUSY_CYC);
        st_q <= S_IDLE;
      end else if (ev_byte) begin
        case (st_q)
          S_DEV: begin
            if (rx_byte[7:1] == DEV_ID && !rx_byte[0]) begin
              ack_q <= 1'b1;
              st_q  <= S_AHI;
            end else begin
              st_q  <= S_IDLE;
            end
          end
          S_AHI: begin
            ack_q        <= 1'b1;
            wptr_q[15:8] <= rx_byte;
            st_q         <= S_ALO;
          end
          S_ALO: begin
            ack_q  <= 1'b1;
            wptr_q <= nxt_addr;
            rg_q   <= nxt_rg;
            drop_q <= nxt_drop;
            st_q   <= S_DATA;
          end
          S_DATA: begin
            ack_q  <= 1'b1;
            got_q  <= 1'b1;
            wptr_q <= step_addr(wptr_q, msk);
          end
          default: ;
        endcase
      end
    end
  end

  assign ack       = ack_q;
  assign wptr      = wptr_q;
  assign cm_region = rg_q;
  assign cm_base   = wptr_q & ~msk;

endmodule

// File: rtl/pgwr_store.sv
module pgwr_store
  import pgwr_pkg::*;
#(
  parameter int          ARR_BYTES = 256,
  parameter int          ARR_PAGE  = 64,
  parameter int          CTL_PAGE  = 8,
  parameter logic [15:0] CTL_BASE  = 16'h4000,
  parameter logic [15:0] STAT_ADDR = 16'h400F,
  localparam int AW  = $clog2(ARR_BYTES),
  localparam int PBW = $clog2(ARR_PAGE),
  localparam int CBW = $clog2(CTL_PAGE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  region_e                  cm_region,
  input  logic [15:0]              cm_base,
  input  logic [ARR_PAGE-1:0][7:0] pb_data,
  input  logic [ARR_PAGE-1:0]      pb_vld,
  input  logic [15:0]              peek_addr,
  output logic [7:0]               peek_data,
  output logic [1:0]               prot_bits,
  output logic                     ctl_open
);

  logic [7:0] mem [ARR_BYTES];
  logic [7:0] ctl [CTL_PAGE];
  logic [7:0] stat_q;
  lock_e      lk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ARR_BYTES; j++) mem[j] <= '0;
    end else if (commit && cm_region == RG_ARR) begin
      for (int j = 0; j < ARR_BYTES; j++)
        if ((16'(j) >> PBW) == (cm_base >> PBW) && pb_vld[j % ARR_PAGE])
          mem[j] <= pb_data[j % ARR_PAGE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CTL_PAGE; k++) ctl[k] <= '0;
    end else if (commit && cm_region == RG_CTL) begin
      for (int k = 0; k < CTL_PAGE; k++)
        if (pb_vld[k]) ctl[k] <= pb_data[k];
    end
  end

  // Two-step unlock: 02h arms, a later 06h opens, anything else shuts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      lk_q   <= LK_SHUT;
    end else if (commit && cm_region == RG_STAT && pb_vld[0]) begin
      stat_q <= pb_data[0];
      if (pb_data[0] == 8'h02)
        lk_q <= LK_ARMED;
      else if (pb_data[0] == 8'h06 && lk_q != LK_SHUT)
        lk_q <= LK_OPEN;
      else
        lk_q <= LK_SHUT;
    end
  end

  always_comb begin
    case (region_of(peek_addr, ARR_BYTES, CTL_BASE, CTL_PAGE, STAT_ADDR))
      RG_ARR:  peek_data = mem[peek_addr[AW-1:0]];
      RG_CTL:  peek_data = ctl[peek_addr[CBW-1:0]];
      RG_STAT: peek_data = stat_q;
      default: peek_data = 8'h00;
    endcase
  end

  assign prot_bits = ctl[0][1:0];
  assign ctl_open  = lk_q == LK_OPEN;

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter logic [6:0]  DEV_ID    = 7'h6F,
  parameter int          BUSY_CYC  = 40,
  parameter int          ARR_BYTES = 256,
  parameter int          ARR_PAGE  = 64,
  parameter int          CTL_PAGE  = 8,
  parameter logic [15:0] CTL_BASE  = 16'h4000,
  parameter logic [15:0] STAT_ADDR = 16'h400F,
  localparam int CW = $clog2(ARR_PAGE)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        ev_byte,
  input  logic [7:0]  rx_byte,
  input  logic        mid_byte,
  output logic        ack,
  output logic        busy,
  output logic [15:0] wptr,
  input  logic [15:0] peek_addr,
  output logic [7:0]  peek_data
);

  logic [1:0]               prot_bits;
  logic                     ctl_open, ld_en, clr, commit, stop_commit;
  logic [CW-1:0]            ld_col;
  region_e                  cm_region;
  logic [15:0]              cm_base;
  logic [ARR_PAGE-1:0][7:0] pb_data;
  logic [ARR_PAGE-1:0]      pb_vld;

  pgwr_seq #(
    .DEV_ID(DEV_ID), .BUSY_CYC(BUSY_CYC), .ARR_BYTES(ARR_BYTES), .ARR_PAGE(ARR_PAGE),
    .CTL_PAGE(CTL_PAGE), .CTL_BASE(CTL_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .mid_byte(mid_byte),
    .prot_bits(prot_bits), .ctl_open(ctl_open), .ack(ack), .busy(busy),
    .wptr(wptr), .ld_en(ld_en), .ld_col(ld_col), .clr(clr), .commit(commit),
    .stop_commit(stop_commit), .cm_region(cm_region), .cm_base(cm_base)
  );

  pgwr_pagebuf #(.PAGE(ARR_PAGE)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_en(ld_en), .ld_col(ld_col),
    .ld_data(rx_byte), .pb_data(pb_data), .pb_vld(pb_vld)
  );

  pgwr_store #(
    .ARR_BYTES(ARR_BYTES), .ARR_PAGE(ARR_PAGE), .CTL_PAGE(CTL_PAGE),
    .CTL_BASE(CTL_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cm_region(cm_region),
    .cm_base(cm_base), .pb_data(pb_data), .pb_vld(pb_vld),
    .peek_addr(peek_addr), .peek_data(peek_data), .prot_bits(prot_bits),
    .ctl_open(ctl_open)
  );

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int ARR_PAGE = 64,
  localparam int PBW = $clog2(ARR_PAGE)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_byte,
  input logic        ev_stop,
  input logic        mid_byte,
  input logic        ack,
  input logic        busy,
  input logic [15:0] wptr,
  input logic        ld_en,
  input logic        commit,
  input logic        stop_commit
);

  // R2
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(ev_byte));

  // R8
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ack);

  // R3
  page_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> wptr[15:PBW] == $past(wptr[15:PBW]));

  // R7
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && mid_byte && !busy) |=> !busy);

  // R6
  cycle_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_commit |=> busy);

  // R6
  cycle_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.ARR_PAGE(ARR_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_byte(ev_byte), .ev_stop(ev_stop),
  .mid_byte(mid_byte), .ack(ack), .busy(busy), .wptr(wptr), .ld_en(ld_en),
  .commit(commit), .stop_commit(stop_commit)
);

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int BUSY  = 12;
  localparam logic [6:0] DEV = 7'h6F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, mid_byte = 0;
  logic [7:0] rx_byte = 0, peek_data;
  logic [15:0] peek_addr = 0, wptr;
  logic ack, busy;
  int total = 0, bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  pgwr_ctrl #(.DEV_ID(DEV), .BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .mid_byte(mid_byte), .ack(ack),
    .busy(busy), .wptr(wptr), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int md_st, md_cnt, md_addr, md_reg, md_lock;
  bit md_drop, md_got, md_ack;
  logic [7:0] md_ctl0;
  logic [7:0] md_pend [int];

  function automatic int m_region(int a);
    if (a < 256) return 1;
    if (a >= 'h4000 && a < 'h4008) return 2;
    if (a == 'h400F) return 3;
    return 0;
  endfunction

  function automatic int m_pg(int r);
    return (r == 1) ? 64 : (r == 2) ? 8 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      md_st = 0; md_cnt = 0; md_addr = 0; md_reg = 0; md_lock = 0;
      md_drop = 1; md_got = 0; md_ack = 0; md_ctl0 = 0; md_pend.delete();
    end else if (md_cnt > 0) begin
      if (md_cnt == 1) begin
        foreach (md_pend[k]) begin
          if (md_reg == 2 && k == 'h4000) md_ctl0 = md_pend[k];
          if (md_reg == 3) begin
            if (md_pend[k] == 8'h02) md_lock = 1;
            else if (md_pend[k] == 8'h06 && md_lock != 0) md_lock = 2;
            else md_lock = 0;
          end
        end
      end
      md_cnt--; md_ack = 0;
    end else begin
      md_ack = 0;
      if (ev_start) begin
        md_st = 1; md_got = 0; md_pend.delete();
      end else if (ev_stop) begin
        if (md_st == 4 && md_got && !mid_byte && !md_drop) md_cnt = BUSY;
        md_st = 0;
      end else if (ev_byte) begin
        if (md_st == 1) begin
          if (rx_byte == {DEV, 1'b0}) begin md_ack = 1; md_st = 2; end
          else md_st = 0;
        end else if (md_st == 2) begin
          md_ack = 1; md_addr = (int'(rx_byte) << 8) | (md_addr & 255); md_st = 3;
        end else if (md_st == 3) begin
          int bp, pr;
          md_ack = 1; md_addr = (md_addr & 'hFF00) | int'(rx_byte);
          md_reg = m_region(md_addr);
          bp = int'(md_ctl0) & 3;
          pr = (bp == 3) || (bp == 2 && md_addr >= 128) || (bp == 1 && md_addr >= 192);
          md_drop = (md_reg == 0) || (md_reg == 1 && pr != 0) || (md_reg == 2 && md_lock != 2);
          md_st = 4;
        end else if (md_st == 4) begin
          int pg, base;
          md_ack = 1; md_got = 1; md_pend[md_addr] = rx_byte;
          pg = m_pg(md_reg); base = md_addr - (md_addr % pg);
          md_addr = base + ((md_addr % pg) + 1) % pg;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ack vs model", ack, md_ack);
      chk("R6 busy vs model", busy, md_cnt > 0);
      chk("R3 wptr vs model", wptr, md_addr[15:0]);
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic do_start();
    ev_start = 1; @(negedge clk); ev_start = 0;
  endtask

  task automatic send(input logic [7:0] b, output bit a);
    ev_byte = 1; rx_byte = b; @(negedge clk); ev_byte = 0; a = ack;
  endtask

  task automatic do_stop(input bit mid);
    ev_stop = 1; mid_byte = mid; @(negedge clk); ev_stop = 0; mid_byte = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d[$], input bit mid,
                    output bit all_ack);
    bit k;
    all_ack = 1;
    do_start();
    send({DEV, 1'b0}, k); all_ack &= k;
    send(a[15:8], k);     all_ack &= k;
    send(a[7:0], k);      all_ack &= k;
    foreach (d[i]) begin send(d[i], k); all_ack &= k; end
    do_stop(mid);
  endtask

  task automatic drain(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic pk(input logic [15:0] a, output logic [7:0] v);
    peek_addr = a; #1; v = peek_data;
  endtask

  task automatic pchk(input string tag, input logic [15:0] a, input logic [7:0] e);
    logic [7:0] v;
    pk(a, v); chk(tag, v, e);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    bit ak; int n; logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 ack", ack, 0); chk("R11 busy", busy, 0); chk("R11 wptr", wptr, 0);
    pchk("R11 array", 16'h0000, 0); pchk("R11 ctl", 16'h4000, 0);

    q = {8'hA5};
    wr(16'h0005, q, 0, ak); chk("R1 R2 acks", ak, 1);
    drain(n); chk("R6 busy length", n, BUSY);
    pchk("R6 loaded byte", 16'h0005, 8'hA5); pchk("R6 neighbour", 16'h0004, 0);
    chk("R2 pointer", wptr, 16'h0006);

    q = {}; for (int i = 0; i < 24; i++) q.push_back(8'h40 + 8'(i));
    wr(16'h0030, q, 0, ak); drain(n);
    chk("R3 pointer after wrap", wptr, 16'h0008);
    pchk("R3 page end", 16'h003F, 8'h4F); pchk("R3 page start", 16'h0000, 8'h50);
    pchk("R3 last", 16'h0007, 8'h57); pchk("R3 untouched", 16'h0008, 0);

    q = {}; for (int i = 0; i < 70; i++) q.push_back(8'(i));
    wr(16'h0040, q, 0, ak); drain(n);
    pchk("R4 overwrite col0", 16'h0040, 8'h40); pchk("R4 overwrite col5", 16'h0045, 8'h45);
    pchk("R4 kept col6", 16'h0046, 8'h06); pchk("R4 kept col63", 16'h007F, 8'h3F);
    chk("R4 pointer", wptr, 16'h0046);

    q = {8'h11};
    wr(16'h0080, q, 1, ak); chk("R7 mid-byte stop busy", busy, 0);
    pchk("R7 array kept", 16'h0080, 0);
    q = {};
    wr(16'h0081, q, 0, ak); chk("R7 no-data stop busy", busy, 0);
    q = {8'h22, 8'h33};
    wr(16'h0082, q, 1, ak); chk("R7 abort after data busy", busy, 0);
    pchk("R7 array kept 2", 16'h0082, 0);

    q = {8'h5A};
    wr(16'h0090, q, 0, ak);
    do_start(); send({DEV, 1'b0}, ak); chk("R8 select during busy", ak, 0);
    send(8'h00, ak); chk("R8 byte during busy", ak, 0);
    drain(n);
    send(8'h00, ak); chk("R8 byte without start", ak, 0);
    pchk("R6 committed", 16'h0090, 8'h5A);

    do_start(); send(8'hA0, ak); chk("R1 wrong id", ak, 0);
    send(8'h00, ak); chk("R1 silent after mismatch", ak, 0);
    do_start(); send({DEV, 1'b1}, ak); chk("R1 read bit", ak, 0);
    do_stop(0);

    q = {8'h03};
    wr(16'h4000, q, 0, ak); chk("R10 locked acks", ak, 1); chk("R10 locked busy", busy, 0);
    pchk("R10 locked ctl", 16'h4000, 0);
    q = {8'h06}; wr(16'h400F, q, 0, ak); drain(n);
    q = {8'h44}; wr(16'h4001, q, 0, ak); chk("R10 06 alone busy", busy, 0);
    q = {8'h02, 8'h06}; wr(16'h400F, q, 0, ak); drain(n);
    q = {8'h44}; wr(16'h4001, q, 0, ak); chk("R10 single write busy", busy, 0);
    q = {8'h02}; wr(16'h400F, q, 0, ak); drain(n);
    q = {8'h06}; wr(16'h400F, q, 0, ak); drain(n);
    pchk("R10 status value", 16'h400F, 8'h06);

    q = {8'h15, 8'h16, 8'h17, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25};
    wr(16'h4005, q, 0, ak); drain(n); chk("R10 open busy", n, BUSY);
    chk("R5 pointer", wptr, 16'h4006);
    pchk("R5 col5", 16'h4005, 8'h25); pchk("R5 col7", 16'h4007, 8'h17);
    pchk("R5 col0", 16'h4000, 8'h20); pchk("R5 col4", 16'h4004, 8'h24);

    q = {8'h01}; wr(16'h4000, q, 0, ak); drain(n);
    q = {8'h77, 8'h78};
    wr(16'h00C0, q, 0, ak); chk("R9 protected acks", ak, 1); chk("R9 protected busy", busy, 0);
    pchk("R9 protected kept", 16'h00C0, 0);
    q = {8'h88};
    wr(16'h0080, q, 0, ak); chk("R9 later acks", ak, 1); drain(n); chk("R9 open busy", n, BUSY);
    pchk("R9 open write", 16'h0080, 8'h88);
    q = {8'h02}; wr(16'h4000, q, 0, ak); drain(n);
    q = {8'h99}; wr(16'h0080, q, 0, ak); chk("R9 half busy", busy, 0);
    pchk("R9 half kept", 16'h0080, 8'h88);

    q = {8'h00}; wr(16'h400F, q, 0, ak); drain(n);
    q = {8'h00}; wr(16'h4000, q, 0, ak); chk("R10 relocked busy", busy, 0);
    pchk("R10 relocked ctl", 16'h4000, 8'h02);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule